// File: doc/BRIEF.md
# Dual-Output PWM Generator with Synchronized Shadow Updates

This block produces two pulse-width-modulated outputs, A and B, from one free-running counter. The counter steps from 0 up to a programmable period value and then wraps. Each output is driven high when the counter reaches that output's "on" compare and low when it reaches its "off" compare. A one-clock pulse marks the clock on which the counter wraps, which is the cycle boundary.

Software reaches the block through a plain register port with a write strobe, a write address, write data and a separate combinational read address. Every timing value (four compares and the period), the output-enable bits and the fifty-percent mode bit are written into a shadow copy. The shadow copy moves into the working copy in one step, and only on a cycle boundary. Two controls decide whether that move happens. A hold bit blocks it. An automatic mode permits it only when the most recent timing write went to the B "off" compare, so a whole set can be written and then committed by that final write. The automatic mode overrides the hold bit. In fifty-percent mode, channel A reuses channel B's compares. A run bit starts and stops the block. While stopped, the working copy follows the shadow copy on every clock, so the first cycle after a start uses the latest values.

Top module: `pwm_dual_sync`

## Requirements
- R1: After reset, pwm_a, pwm_b and cycle_end are 0 and every register reads 0.
- R2: While running, the counter counts 0,1,...,P, where P is the working period. cycle_end is 1 during exactly the clock in which the counter equals P, and the counter is 0 on the next clock.
- R3: When the counter equals an output's working "on" compare, that output is 1 on the following clock. When it equals the "off" compare, the output is 0 on the following clock. If the two compares are equal, "off" wins. Otherwise the output keeps its level. An output is forced to 0 while its enable bit in the config register (address 5, bit 0 for A, bit 1 for B) is 0.
- R4: The shadow set moves into the working set as a whole, and only on a clock where cycle_end is 1 and an update is pending. The shadow set is: A-on (address 0), A-off (1), B-on (2), B-off (3), period (4) and config (5). Any write to addresses 0 to 5 makes an update pending.
- R5: With the hold bit (control address 6, bit 1) at 1 and the automatic mode not in effect, no update takes place. After the hold bit returns to 0, the pending set is applied at the next cycle boundary.
- R6: While the automatic mode is in effect, an update is pending only if the most recent write to addresses 0 to 5 went to address 3 (B-off).
- R7: A write to the automatic-mode bit (control bit 2) takes effect at the next cycle boundary, or on the next clock while stopped.
- R8: While the automatic mode is in effect, the hold bit has no influence on updates.
- R9: With config bit 2 set, channel A uses the working B-on and B-off values as its own compares.
- R10: With the run bit (control bit 0) at 0, the counter stays at 0, both outputs are 0 and the working set copies the shadow set on every clock. Clearing the run bit mid-cycle ends the cycle at once, and setting it starts a fresh cycle from 0 with the current shadow values.
- R11: rd_data returns the shadow value at rd_addr (addresses 0 to 5), the control bits at address 6, and 0 at address 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | W | Read data (combinational) |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |
| cycle_end | output | 1 | One-clock cycle-boundary pulse |

## Verification
Faults in this block show up at the ports in the following ways:
- A wrong pending flag or a wrong automatic-mode state moves pulse edges to different counter positions. This is visible no later than one full period after the cycle boundary where the update should or should not have happened.
- A counter fault changes the spacing of cycle_end at once.
- A shadow-register fault appears on rd_data as soon as the register is addressed.

The bench compares all outputs against its own model on every clock, so a difference is reported in the cycle where it first appears.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int AW       = 3;
  localparam int ADR_AON  = 0;
  localparam int ADR_AOFF = 1;
  localparam int ADR_BON  = 2;
  localparam int ADR_BOFF = 3;
  localparam int ADR_PER  = 4;
  localparam int ADR_CFG  = 5;
  localparam int ADR_CTL  = 6;
  localparam int CFG_W    = 3;   // en_a, en_b, fifty
  localparam int NCMP     = 4;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_sync_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic [AW-1:0]            rd_addr,
  input  logic                     auto_live,
  input  logic                     commit,
  output logic [NCMP-1:0][W-1:0]   shd_cmp,
  output logic [W-1:0]             shd_per,
  output logic [CFG_W-1:0]         shd_cfg,
  output logic                     run,
  output logic                     hold,
  output logic                     auto_req,
  output logic                     pending,
  output logic [W-1:0]             rd_data
);
  logic set_wr;
  assign set_wr = wr_en && (int'(wr_addr) <= ADR_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_cmp  <= '0;
      shd_per  <= '0;
      shd_cfg  <= '0;
      run      <= 1'b0;
      hold     <= 1'b0;
      auto_req <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (wr_en) begin
        case (int'(wr_addr))
          ADR_AON, ADR_AOFF, ADR_BON, ADR_BOFF: shd_cmp[wr_addr[1:0]] <= wr_data;
          ADR_PER: shd_per <= wr_data;
          ADR_CFG: shd_cfg <= wr_data[CFG_W-1:0];
          ADR_CTL: begin
            run      <= wr_data[0];
            hold     <= wr_data[1];
            auto_req <= wr_data[2];
          end
          default: ;
        endcase
      end
      if (set_wr)
        pending <= auto_live ? (int'(wr_addr) == ADR_BOFF) : 1'b1;
      else if (commit)
        pending <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (int'(rd_addr))
      ADR_AON, ADR_AOFF, ADR_BON, ADR_BOFF: rd_data = shd_cmp[rd_addr[1:0]];
      ADR_PER: rd_data = shd_per;
      ADR_CFG: rd_data[CFG_W-1:0] = shd_cfg;
      ADR_CTL: rd_data[2:0] = {auto_req, hold, run};
      default: ;
    endcase
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = run && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || wrap)   cnt <= '0;
    else                     cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] on_v,
  input  logic [W-1:0] off_v,
  input  logic         en,
  output logic         pin
);
  logic lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lvl <= 1'b0;
    else if (!run)           lvl <= 1'b0;
    else if (cnt == off_v)   lvl <= 1'b0;
    else if (cnt == on_v)    lvl <= 1'b1;
  end

  assign pin = lvl & en;
endmodule

// File: rtl/pwm_dual_sync.sv
module pwm_dual_sync
  import pwm_sync_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [2:0]    rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          cycle_end
);
  localparam int NCH = 2;

  logic [NCMP-1:0][W-1:0] shd_cmp, act_cmp;
  logic [W-1:0]           shd_per, act_per, cnt;
  logic [CFG_W-1:0]       shd_cfg, act_cfg;
  logic run, hold, auto_req, auto_live, pending, commit, wrap;
  logic [NCH-1:0]         pins;

  pwm_shadow_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .auto_live(auto_live),
    .commit(commit), .shd_cmp(shd_cmp), .shd_per(shd_per),
    .shd_cfg(shd_cfg), .run(run), .hold(hold), .auto_req(auto_req),
    .pending(pending), .rd_data(rd_data)
  );

  pwm_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .period(act_per),
    .cnt(cnt), .wrap(wrap)
  );

  // Stopped: follow shadow every clock. Running: only at a boundary.
  assign commit = !run || (wrap && pending && (auto_live || !hold));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cmp   <= '0;
      act_per   <= '0;
      act_cfg   <= '0;
      auto_live <= 1'b0;
    end else begin
      if (commit) begin
        act_cmp <= shd_cmp;
        act_per <= shd_per;
        act_cfg <= shd_cfg;
      end
      if (!run || wrap) auto_live <= auto_req;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [W-1:0] on_v, off_v;
    if (ch == 0) begin : g_a
      assign on_v  = act_cfg[2] ? act_cmp[ADR_BON]  : act_cmp[ADR_AON];
      assign off_v = act_cfg[2] ? act_cmp[ADR_BOFF] : act_cmp[ADR_AOFF];
    end else begin : g_b
      assign on_v  = act_cmp[ADR_BON];
      assign off_v = act_cmp[ADR_BOFF];
    end
    pwm_chan #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
      .on_v(on_v), .off_v(off_v), .en(act_cfg[ch]), .pin(pins[ch])
    );
  end

  assign pwm_a     = pins[0];
  assign pwm_b     = pins[1];
  assign cycle_end = wrap;
endmodule

// File: rtl/pwm_sync_chk.sv
module pwm_sync_chk
  import pwm_sync_pkg::*;
#(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic          run,
  input logic          hold,
  input logic          auto_live,
  input logic          commit,
  input logic [W-1:0]  cnt,
  input logic          cycle_end,
  input logic          pwm_a,
  input logic          pwm_b
);
  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> (cnt == '0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cycle_end) |=> (cnt == W'($past(cnt) + 1)));

  // R4
  commit_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && commit) |-> cycle_end);

  // R5
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold && !auto_live) |-> !commit);

  // R6
  auto_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && auto_live && wr_en && int'(wr_addr) <= ADR_CFG && int'(wr_addr) != ADR_BOFF)
      |=> (!run || !commit));

  // R10
  stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pwm_a && !pwm_b));
endmodule

bind pwm_dual_sync pwm_sync_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .run(run), .hold(hold), .auto_live(auto_live), .commit(commit),
  .cnt(cnt), .cycle_end(cycle_end), .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/tb_pwm_dual_sync.sv
module tb_pwm_dual_sync;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic pwm_a, pwm_b, cycle_end;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  pwm_dual_sync #(.W(W)) dut (.*);

  // behavioural reference model
  int sh[6];          // 0..3 compares, 4 period, 5 cfg
  int ac[6];
  int c_run, c_hold, c_auto, pend, auto_on, cnt, oa, ob;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (sh[i]) begin sh[i] = 0; ac[i] = 0; end
      c_run = 0; c_hold = 0; c_auto = 0; pend = 0; auto_on = 0; cnt = 0; oa = 0; ob = 0;
    end else begin
      int eoc, a_on, a_off, xf, npend;
      eoc   = (c_run != 0 && cnt == ac[4]);
      a_on  = ac[5][2] ? ac[2] : ac[0];
      a_off = ac[5][2] ? ac[3] : ac[1];
      if (c_run == 0) begin oa = 0; ob = 0; end
      else begin
        if (cnt == a_off) oa = 0; else if (cnt == a_on) oa = 1;
        if (cnt == ac[3]) ob = 0; else if (cnt == ac[2]) ob = 1;
      end
      xf = (c_run == 0) || (eoc != 0 && pend != 0 && (auto_on != 0 || c_hold == 0));
      npend = xf ? 0 : pend;
      if (wr_en && wr_addr <= 3'd5) npend = (auto_on != 0) ? int'(wr_addr == 3'd3) : 1;
      if (c_run == 0 || eoc != 0) auto_on = c_auto;
      cnt = (c_run == 0 || eoc != 0) ? 0 : (cnt + 1) % 256;
      if (xf) foreach (sh[i]) ac[i] = sh[i];
      pend = npend;
      if (wr_en) begin
        if (wr_addr <= 3'd4) sh[wr_addr] = int'(wr_data);
        else if (wr_addr == 3'd5) sh[5] = int'(wr_data[2:0]);
        else if (wr_addr == 3'd6) begin
          c_run = wr_data[0]; c_hold = wr_data[1]; c_auto = wr_data[2];
        end
      end
    end
  end

  always @(posedge clk) rd_addr <= rd_addr + 3'd1;

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      int er;
      case (rd_addr)
        3'd6: er = c_run + 2 * c_hold + 4 * c_auto;
        3'd7: er = 0;
        default: er = sh[rd_addr];
      endcase
      chk("R3 pwm_a", pwm_a, oa & ac[5][0]);
      chk("R3 pwm_b", pwm_b, ob & ac[5][1]);
      chk("R2 cycle_end", cycle_end, int'(c_run != 0 && cnt == ac[4]));
      chk("R11 rd_data", int'(rd_data), er);
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired, got hang expected completion");
    report();
  end

  initial begin
    tag = "R1";
    idle(4);
    #2 rst_n = 1'b1;
    idle(10);
    tag = "R11";
    wr(0, 2); wr(1, 6); wr(2, 4); wr(3, 8); wr(4, 9); wr(5, 3);
    idle(10);
    tag = "R2";
    wr(6, 1); idle(30);
    tag = "R4";
    wr(0, 1); wr(1, 3); wr(4, 12); idle(30);
    tag = "R3";
    wr(2, 5); wr(3, 5); idle(30);
    wr(5, 1); idle(20); wr(5, 3);
    tag = "R5";
    wr(6, 3); wr(2, 2); wr(3, 10); idle(40);
    wr(6, 1); idle(30);
    tag = "R8";
    wr(6, 7); idle(30);
    tag = "R6";
    wr(3, 6); wr(0, 4); idle(40);
    wr(3, 9); idle(30);
    tag = "R7";
    idle(3); wr(6, 3); wr(1, 7); idle(40);
    tag = "R9";
    wr(6, 1); wr(5, 7); idle(35);
    wr(4, 0); idle(10); wr(4, 11); idle(30);
    tag = "R10";
    idle(5); wr(6, 0); idle(6);
    wr(2, 1); wr(3, 4); idle(3);
    wr(6, 1); idle(30);
    report();
  end
endmodule